// File: doc/BRIEF.md
# Three-Bank Clock Divider with Output-Enable Decode

This block sits behind a fast synthesizer clock (nominally 500 MHz) and derives three banks of three clock outputs each, plus one free-running reference output. It uses a single phase counter to make three symmetric divided clocks. The ratios are 4 (125 MHz, used by banks B and C), 10 (50 MHz) and 20 (25 MHz). Bank A runs at 25 or 50 MHz, depending on the configuration.

A 3-bit configuration code selects which of the nine bank outputs toggle and which are parked in high impedance. Each output reports high impedance through its own enable flag. Bank C is modelled as true/complement pairs. A new code is applied only when the slowest clock restarts its period, so an enabled output never emits a shortened pulse. A synchronous active-low reset clears all divider state and forces a fixed output pattern.

Top module: `clkbank_top`

## Requirements
- R1: With the defaults, the fast clock has a period of 4 input cycles (2 high, 2 low), the mid clock a period of 10 (5/5) and the slow clock a period of 20 (10/10). Bank B outputs and bank C true outputs carry the fast clock when enabled.
- R2: On the first clock edge after reset is released, all three divided clocks go high together. From then on, every rising edge of the slow clock coincides with a rising edge of the fast clock and of the mid clock.
- R3: `ref_clk` carries the slow clock for every configuration code, including 3'b111.
- R4: While `rst_n` is sampled low, the outputs after that edge are as follows: every single-ended output and every pair true output is 0, and every pair complement output is 1. The code present at `cfg_code` is taken as the active configuration during reset.
- R5: Enable decode, with bits written as output index 2..0. 000 gives A=001, B=000, C=001. 001 gives A=001, B=001, C=001. 010 gives A=011, B=000, C=011. 011 enables all nine outputs. 100 gives A=001, B=000, C=001. 101 gives A=011, B=011, C=011. 110 gives A=011, B=000, C=011. 111 disables all nine outputs.
- R6: Bank A carries the mid (50 MHz) clock for codes 100 and 110, and the slow (25 MHz) clock for every other code.
- R7: Outside reset, a change on `cfg_code` becomes active only at the clock edge where the slow clock starts a new period. The code sampled at that edge applies from the following cycle. Enable flags never change while `ref_clk` is high, or in the cycle after it was high.
- R8: A disabled output drives its enable flag to 0. A disabled single-ended output reads 0. A disabled pair reads true 0 and complement 1.
- R9: An enabled pair always drives its complement output as the inverse of its true output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| cfg_code | input | 3 | Output-enable / bank-A rate configuration code |
| a_clk | output | 3 | Bank A single-ended clocks |
| a_oe | output | 3 | Bank A enable flags (0 = high impedance) |
| b_clk | output | 3 | Bank B single-ended clocks |
| b_oe | output | 3 | Bank B enable flags |
| c_p | output | 3 | Bank C pair true outputs |
| c_n | output | 3 | Bank C pair complement outputs |
| c_oe | output | 3 | Bank C enable flags |
| ref_clk | output | 1 | Ungated slow reference clock |

## Verification
Every one of the eight configuration codes is held for 37 cycles, a count that is not a multiple of 20. Each code change therefore lands in the middle of a slow period, which separates a design that applies the code at once from one that waits for the period boundary. The two rate-selecting codes (100, 110) are placed next to 25 MHz codes, so a wrong bank-A source shows up as a phase mismatch within a few cycles. The all-off code checks that the reference clock keeps running when every bank output is disabled. A reset in the middle of the run, with a different code, checks that divider phase restarts aligned and that the code captured during reset takes effect immediately.

// File: rtl/clkbank_pkg.sv
// Package: shared constants, the bank selection record and the code decoder.
// Assumes three outputs per bank and a 3-bit configuration code.
package clkbank_pkg;

    localparam int NUM_OUT = 3;
    localparam int CFG_W   = 3;

    // Decoded selection: rate pick for bank A plus per-output enables.
    typedef struct packed {
        logic               a_fast;
        logic [NUM_OUT-1:0] en_a;
        logic [NUM_OUT-1:0] en_b;
        logic [NUM_OUT-1:0] en_c;
    } bank_sel_t;

    // Map a configuration code to its enable set and bank-A rate.
    function automatic bank_sel_t decode_sel(input logic [CFG_W-1:0] code);
        bank_sel_t s;
        s = '0;
        case (code)
            3'b000: begin s.en_a = 3'b001; s.en_c = 3'b001; end
            3'b001: begin s.en_a = 3'b001; s.en_b = 3'b001; s.en_c = 3'b001; end
            3'b010: begin s.en_a = 3'b011; s.en_c = 3'b011; end
            3'b011: begin s.en_a = 3'b111; s.en_b = 3'b111; s.en_c = 3'b111; end
            3'b100: begin s.en_a = 3'b001; s.en_c = 3'b001; s.a_fast = 1'b1; end
            3'b101: begin s.en_a = 3'b011; s.en_b = 3'b011; s.en_c = 3'b011; end
            3'b110: begin s.en_a = 3'b011; s.en_c = 3'b011; s.a_fast = 1'b1; end
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/clkbank_phase_gen.sv
// Phase generator: one modulo-DIV_SLOW counter feeds three registered
// divided clocks, so all of them share phase and rise together at count 0.
// Assumes DIV_SLOW is a multiple of DIV_FAST and DIV_MID, and all are even.
module clkbank_phase_gen #(
    parameter int DIV_FAST = 4,
    parameter int DIV_MID  = 10,
    parameter int DIV_SLOW = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [2:0] ph,      // [0] fast, [1] mid, [2] slow
    output logic       wrap     // last count of the slow period
);
    localparam int CNT_W    = $clog2(DIV_SLOW);
    localparam int DIVS [3] = '{DIV_FAST, DIV_MID, DIV_SLOW};

    logic [CNT_W-1:0] cnt;

    assign wrap = (cnt == CNT_W'(DIV_SLOW - 1));

    // Shared phase counter, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wrap) cnt <= '0;
        else           cnt <= cnt + CNT_W'(1);
    end

    for (genvar g = 0; g < 3; g++) begin : g_div
        // Registered 50% clock: high for the first half of each sub-period.
        always_ff @(posedge clk) begin
            if (!rst_n) ph[g] <= 1'b0;
            else        ph[g] <= ((int'(cnt) % DIVS[g]) < (DIVS[g] / 2));
        end
    end

endmodule

// File: rtl/clkbank_cfg_hold.sv
// Configuration holder: keeps the active code, loads it freely in reset and
// otherwise only at the slow-period wrap, then decodes it.
// Assumes wrap is asserted in the cycle whose edge restarts the slow period.
module clkbank_cfg_hold
    import clkbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_in,
    input  logic             wrap,
    output bank_sel_t        sel
);
    logic [CFG_W-1:0] code_q;

    // Capture the code during reset or at the period boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n || wrap) code_q <= cfg_in;
    end

    // Decode the held code.
    always_comb sel = decode_sel(code_q);

endmodule

// File: rtl/clkbank_out_stage.sv
// Output stage: gates the divided clocks per output and builds the parked
// values for disabled outputs (single-ended 0, pair 0/1).
// Assumes ph inputs are glitch-free registered clocks.
module clkbank_out_stage
    import clkbank_pkg::*;
(
    input  bank_sel_t          sel,
    input  logic               ph_fast,
    input  logic               ph_mid,
    input  logic               ph_slow,
    output logic [NUM_OUT-1:0] a_clk,
    output logic [NUM_OUT-1:0] a_oe,
    output logic [NUM_OUT-1:0] b_clk,
    output logic [NUM_OUT-1:0] b_oe,
    output logic [NUM_OUT-1:0] c_p,
    output logic [NUM_OUT-1:0] c_n,
    output logic [NUM_OUT-1:0] c_oe
);
    logic a_src;

    // Bank A rate pick.
    assign a_src = sel.a_fast ? ph_mid : ph_slow;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        assign a_oe[i]  = sel.en_a[i];
        assign a_clk[i] = sel.en_a[i] & a_src;
        assign b_oe[i]  = sel.en_b[i];
        assign b_clk[i] = sel.en_b[i] & ph_fast;
        assign c_oe[i]  = sel.en_c[i];
        assign c_p[i]   = sel.en_c[i] & ph_fast;
        assign c_n[i]   = ~(sel.en_c[i] & ph_fast);
    end

endmodule

// File: rtl/clkbank_top.sv
// Top: three-bank clock divider with enable decode and an ungated slow
// reference. Assumes clk is the fast source clock and rst_n is synchronous.
module clkbank_top
    import clkbank_pkg::*;
#(
    parameter int DIV_FAST = 4,
    parameter int DIV_MID  = 10,
    parameter int DIV_SLOW = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CFG_W-1:0]   cfg_code,
    output logic [NUM_OUT-1:0] a_clk,
    output logic [NUM_OUT-1:0] a_oe,
    output logic [NUM_OUT-1:0] b_clk,
    output logic [NUM_OUT-1:0] b_oe,
    output logic [NUM_OUT-1:0] c_p,
    output logic [NUM_OUT-1:0] c_n,
    output logic [NUM_OUT-1:0] c_oe,
    output logic               ref_clk
);
    logic [2:0] ph;
    logic       wrap;
    logic       ph_fast, ph_mid, ph_slow;
    bank_sel_t  sel;

    clkbank_phase_gen #(
        .DIV_FAST (DIV_FAST),
        .DIV_MID  (DIV_MID),
        .DIV_SLOW (DIV_SLOW)
    ) phase_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ph    (ph),
        .wrap  (wrap)
    );

    assign ph_fast = ph[0];
    assign ph_mid  = ph[1];
    assign ph_slow = ph[2];

    clkbank_cfg_hold cfg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_in (cfg_code),
        .wrap   (wrap),
        .sel    (sel)
    );

    clkbank_out_stage out_i (
        .sel     (sel),
        .ph_fast (ph_fast),
        .ph_mid  (ph_mid),
        .ph_slow (ph_slow),
        .a_clk   (a_clk),
        .a_oe    (a_oe),
        .b_clk   (b_clk),
        .b_oe    (b_oe),
        .c_p     (c_p),
        .c_n     (c_n),
        .c_oe    (c_oe)
    );

    // Reference clock is never gated by the configuration.
    assign ref_clk = ph_slow;

endmodule

// File: rtl/clkbank_top_chk.sv
// Checker: temporal properties of the divider, bound into clkbank_top.
module clkbank_top_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ph_fast,
    input logic       ph_mid,
    input logic       ph_slow,
    input logic [2:0] a_clk,
    input logic [2:0] a_oe,
    input logic [2:0] b_clk,
    input logic [2:0] b_oe,
    input logic [2:0] c_p,
    input logic [2:0] c_n,
    input logic [2:0] c_oe,
    input logic       ref_clk
);
    AST_RESET_PATTERN: assert property (@(posedge clk)
        !rst_n |=> (a_clk == 3'b000 && b_clk == 3'b000 && c_p == 3'b000
                    && c_n == 3'b111 && !ref_clk)); // R4

    AST_FAST_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_fast) |=> ph_fast ##1 !ph_fast); // R1

    AST_PHASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_slow) |-> ($rose(ph_fast) && $rose(ph_mid))); // R2

    AST_CFG_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable({a_oe, b_oe, c_oe})) |-> (!ref_clk && !$past(ref_clk))); // R7

    AST_PARKED_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_clk & ~a_oe) == 3'b000 && (b_clk & ~b_oe) == 3'b000
         && (c_p & ~c_oe) == 3'b000 && (c_n | c_oe) == 3'b111)); // R8

    AST_PAIR_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        (c_oe & (c_p ~^ c_n)) == 3'b000); // R9

endmodule

bind clkbank_top clkbank_top_chk chk_i (.*);

// File: tb/clkbank_top_tb_top.sv
// Scoreboard bench: the driver models the expected outputs per edge and
// queues them; the monitor pops and compares two time units after each edge.
module clkbank_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_code = 3'b010;
    logic [2:0] a_clk, a_oe, b_clk, b_oe, c_p, c_n, c_oe;
    logic       ref_clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    clkbank_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_code (cfg_code),
        .a_clk    (a_clk),
        .a_oe     (a_oe),
        .b_clk    (b_clk),
        .b_oe     (b_oe),
        .c_p      (c_p),
        .c_n      (c_n),
        .c_oe     (c_oe),
        .ref_clk  (ref_clk)
    );

    typedef struct {
        logic [2:0] a, aoe, b, boe, cp, cn, coe;
        logic       rf;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    // Bench model state.
    int         m_cnt = 0;
    logic [2:0] m_cfg = 3'b010;
    bit         m_first = 1'b0;

    // Enable table from R5/R6: {fast, A[2:0], B[2:0], C[2:0]}.
    function automatic logic [9:0] tb_table(input logic [2:0] c);
        case (c)
            3'b000: return 10'b0_001_000_001;
            3'b001: return 10'b0_001_001_001;
            3'b010: return 10'b0_011_000_011;
            3'b011: return 10'b0_111_111_111;
            3'b100: return 10'b1_001_000_001;
            3'b101: return 10'b0_011_011_011;
            3'b110: return 10'b1_011_000_011;
            default: return 10'b0_000_000_000;
        endcase
    endfunction

    // Driver: apply inputs for the next edge and queue the expected outputs.
    task automatic step(input logic r, input logic [2:0] c);
        exp_t       e;
        logic       qf, qm, qs;
        logic [9:0] t;
        @(negedge clk);
        rst_n    = r;
        cfg_code = c;
        if (!r) begin
            qf = 0; qm = 0; qs = 0;
            m_cnt = 0; m_cfg = c; m_first = 1'b1;
            e.tag = "R4";
        end else begin
            qf = (m_cnt % 4) < 2;
            qm = (m_cnt % 10) < 5;
            qs = (m_cnt % 20) < 10;
            if (m_cnt == 19) m_cfg = c;
            m_cnt = (m_cnt + 1) % 20;
            e.tag = m_first ? "R2" : "";
            m_first = 1'b0;
        end
        t     = tb_table(m_cfg);
        e.aoe = t[8:6];
        e.boe = t[5:3];
        e.coe = t[2:0];
        e.a   = e.aoe & {3{t[9] ? qm : qs}};
        e.b   = e.boe & {3{qf}};
        e.cp  = e.coe & {3{qf}};
        e.cn  = ~e.cp;
        e.rf  = qs;
        sb_q.push_back(e);
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [2:0] act, input logic [2:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s %s act=%b exp=%b at %0t", tag, what, act, exp_v, $time);
        end
    endtask

    // Monitor: compare after each edge, away from the edge itself.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.tag != "" ? e.tag : "R6", "a_clk",  a_clk, e.a);
            chk(e.tag != "" ? e.tag : "R5", "a_oe",   a_oe,  e.aoe);
            chk(e.tag != "" ? e.tag : "R1", "b_clk",  b_clk, e.b);
            chk(e.tag != "" ? e.tag : "R7", "b_oe",   b_oe,  e.boe);
            chk(e.tag != "" ? e.tag : "R9", "c_p",    c_p,   e.cp);
            chk(e.tag != "" ? e.tag : "R8", "c_n",    c_n,   e.cn);
            chk(e.tag != "" ? e.tag : "R7", "c_oe",   c_oe,  e.coe);
            chk(e.tag != "" ? e.tag : "R3", "ref_clk", {2'b00, ref_clk}, {2'b00, e.rf});
        end
    end

    // Stimulus.
    initial begin
        for (int i = 0; i < 3; i++) step(1'b0, 3'b010);      // R4 reset state
        for (int i = 0; i < 45; i++) step(1'b1, 3'b010);     // R2 alignment, R1
        for (int k = 0; k < 8; k++) begin                    // R5 R6 R7 every code
            for (int i = 0; i < 37; i++) step(1'b1, 3'(k));
        end
        for (int i = 0; i < 30; i++) step(1'b1, 3'b111);     // R3 ref with all off
        for (int i = 0; i < 4; i++) step(1'b0, 3'b101);      // R4 mid-run reset
        for (int i = 0; i < 30; i++) step(1'b1, 3'b110);     // R7 code held from reset
        for (int i = 0; i < 30; i++) step(1'b1, 3'b011);
        @(posedge clk); #3;
        @(posedge clk); #3;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule